// File: doc/BRIEF.md
# Console Terminal Programmed-I/O Port

This block is a console character port on a 16-bit accumulator I/O bus. The processor addresses it with a command class and a 6-bit function code. The four classes are a control pulse, a skip-test, an input into the accumulator and an output from the accumulator. The port answers each command one cycle later with a response pulse. The response carries a skip bit that tells the program the operation succeeded, a load bit, and the accumulator value to load. Bit framing and baud timing are handled elsewhere. The port trades whole bytes with a receive stream and a transmit stream.

Both streams use valid/ready handshakes. On the receive side, the source holds `rx_valid` and `rx_data` until the port raises `rx_ready`. The port raises `rx_ready` only in the cycle in which a character-input command consumes the byte. On the transmit side, the port holds `tx_valid` and `tx_data` unchanged while `tx_ready` is low. It has a single holding register. When that register is full and the sink is not draining it, a newer character is discarded and the held one is kept. The program still receives its skip.

An undefined function code in any class sets a sticky error flag. Only reset clears it.

Top module: `tty_pio_port`

## Requirements
- R1: Each cycle with `cmd_valid` high produces exactly one `resp_valid` pulse on the next cycle, and `resp_valid` is never high otherwise.
- R2: Skip-test function 7 (class 1) skips exactly when `rx_valid` is high, consumes nothing and does not load the accumulator.
- R3: Input (class 2) function 0 or 8 with a character present raises `rx_ready` in the command cycle and answers skip with load. The loaded value is the received byte ORed with 0x80 and then ORed onto the accumulator. For function 0 the accumulator is kept; for function 8 it is cleared first.
- R4: Input function 0 or 8 with no character present answers no skip and no load, keeps `acc_out` equal to the input accumulator, and leaves `rx_ready` low.
- R5: Input function 10 (octal 12) loads the constant 0x0848 (octal 4110), and input function 15 (octal 17) loads 0. Both answer skip.
- R6: Output (class 3) function 0 always answers skip. When the low 8 accumulator bits are non-zero, it queues the low 7 bits with bit 7 cleared for transmit. When they are zero, nothing is sent.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_data` stays stable. A character written while the holding register is occupied and not draining is discarded, and skip is still returned.
- R8: Output function 1 and output functions 4 to 7 answer skip, send nothing and do not load the accumulator.
- R9: All other codes set the sticky `err_flag` and answer no skip. These are every control pulse, any skip-test other than 7, input 1 to 7, 9, 11 to 14 and above 15, and output 2, 3 and above 7.
- R10: After reset, `resp_valid`, `err_flag`, `tx_valid` and `rx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_class | input | 2 | 0 pulse, 1 skip-test, 2 input, 3 output |
| cmd_func | input | 6 | Function code |
| acc_in | input | 16 | Accumulator value with the command |
| resp_valid | output | 1 | Response pulse, one cycle after the command |
| resp_skip | output | 1 | Operation succeeded |
| resp_load | output | 1 | Accumulator is to be loaded from acc_out |
| acc_out | output | 16 | New accumulator value (equals acc_in when not loading) |
| err_flag | output | 1 | Sticky undefined-code flag |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Received byte consumed this cycle |
| tx_valid | output | 1 | Transmit byte held |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The bench builds the port with its default parameters: a 16-bit accumulator, 8-bit characters and the 0x0848 control word. With 8-bit characters, the forced bit 7 on input and the stripped bit 7 on output show up directly in the loaded word and in the transmitted byte. A 16-bit accumulator leaves upper bits above the character that show whether function 0 merged into the accumulator or function 8 cleared it. Holding `tx_ready` low lets the bench reach the full holding register and the discarded second write.

// File: rtl/tty_pio_pkg.sv
package tty_pio_pkg;

  localparam int FN_W = 6;

  typedef enum logic [1:0] {
    CLS_PULSE = 2'd0,
    CLS_TEST  = 2'd1,
    CLS_IN    = 2'd2,
    CLS_OUT   = 2'd3
  } io_class_t;

  typedef enum logic [2:0] {
    OP_BAD,
    OP_TEST_RX,
    OP_GET_CHAR,
    OP_GET_CTRL,
    OP_GET_VEC,
    OP_PUT_CHAR,
    OP_PUT_NOP
  } io_op_t;

  localparam logic [FN_W-1:0] FN_RX_TEST    = 6'o07;
  localparam logic [FN_W-1:0] FN_GET        = 6'o00;
  localparam logic [FN_W-1:0] FN_GET_CLR    = 6'o10;
  localparam logic [FN_W-1:0] FN_GET_CTRL   = 6'o12;
  localparam logic [FN_W-1:0] FN_GET_VEC    = 6'o17;
  localparam logic [FN_W-1:0] FN_PUT        = 6'o00;
  localparam logic [FN_W-1:0] FN_PUT_CTL    = 6'o01;
  localparam logic [FN_W-1:0] FN_PUT_REG_LO = 6'o04;
  localparam logic [FN_W-1:0] FN_PUT_REG_HI = 6'o07;

endpackage

// File: rtl/tty_fn_decode.sv
module tty_fn_decode
  import tty_pio_pkg::*;
(
  input  io_class_t         cls,
  input  logic [FN_W-1:0]   fn,
  output io_op_t            op,
  output logic              clr_first
);

  always_comb begin
    op = OP_BAD;
    case (cls)
      CLS_TEST: begin
        if (fn == FN_RX_TEST) op = OP_TEST_RX;
      end
      CLS_IN: begin
        if (fn == FN_GET || fn == FN_GET_CLR) op = OP_GET_CHAR;
        else if (fn == FN_GET_CTRL)           op = OP_GET_CTRL;
        else if (fn == FN_GET_VEC)            op = OP_GET_VEC;
      end
      CLS_OUT: begin
        if (fn == FN_PUT) op = OP_PUT_CHAR;
        else if (fn == FN_PUT_CTL ||
                 (fn >= FN_PUT_REG_LO && fn <= FN_PUT_REG_HI)) op = OP_PUT_NOP;
      end
      default: op = OP_BAD;
    endcase
  end

  // codes at or above the clearing variant start from an empty accumulator
  assign clr_first = (fn >= FN_GET_CLR);

endmodule

// File: rtl/tty_rx_merge.sv
module tty_rx_merge #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic [AW-1:0] acc,
  input  logic [CW-1:0] ch,
  input  logic          clr,
  output logic [AW-1:0] merged
);

  localparam int PAD = AW - CW;
  localparam logic [CW-1:0] MARK = {1'b1, {(CW-1){1'b0}}};

  logic [AW-1:0] base;
  logic [AW-1:0] ch_wide;

  assign base    = clr ? '0 : acc;
  assign ch_wide = {{PAD{1'b0}}, (ch | MARK)};
  assign merged  = base | ch_wide;

endmodule

// File: rtl/tty_tx_hold.sv
module tty_tx_hold #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [CW-1:0] push_char,
  output logic          tx_valid,
  output logic [CW-1:0] tx_data,
  input  logic          tx_ready
);

  logic room;
  assign room = !tx_valid || tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (push && room) begin
        tx_valid <= 1'b1;
        tx_data  <= {1'b0, push_char[CW-2:0]};
      end
    end
  end

endmodule

// File: rtl/tty_pio_port.sv
module tty_pio_port
  import tty_pio_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            CW        = 8,
  parameter logic [AW-1:0] CTRL_WORD = AW'(12'o4110),
  parameter logic [AW-1:0] VEC_WORD  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_class,
  input  logic [FN_W-1:0] cmd_func,
  input  logic [AW-1:0]   acc_in,
  output logic            resp_valid,
  output logic            resp_skip,
  output logic            resp_load,
  output logic [AW-1:0]   acc_out,
  output logic            err_flag,
  input  logic            rx_valid,
  input  logic [CW-1:0]   rx_data,
  output logic            rx_ready,
  output logic            tx_valid,
  output logic [CW-1:0]   tx_data,
  input  logic            tx_ready
);

  io_op_t        op;
  logic          clr_first;
  logic [AW-1:0] merged;
  logic          push;
  logic          nskip, nload;
  logic [AW-1:0] nacc;

  tty_fn_decode u_dec (
    .cls       (io_class_t'(cmd_class)),
    .fn        (cmd_func),
    .op        (op),
    .clr_first (clr_first)
  );

  tty_rx_merge #(.AW(AW), .CW(CW)) u_merge (
    .acc    (acc_in),
    .ch     (rx_data),
    .clr    (clr_first),
    .merged (merged)
  );

  assign push = cmd_valid && (op == OP_PUT_CHAR) && (|acc_in[CW-1:0]);

  tty_tx_hold #(.CW(CW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_char (acc_in[CW-1:0]),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
  );

  assign rx_ready = cmd_valid && (op == OP_GET_CHAR) && rx_valid;

  always_comb begin
    nskip = 1'b0;
    nload = 1'b0;
    nacc  = acc_in;
    case (op)
      OP_TEST_RX:  nskip = rx_valid;
      OP_GET_CHAR: if (rx_valid) begin
                     nskip = 1'b1;
                     nload = 1'b1;
                     nacc  = merged;
                   end
      OP_GET_CTRL: begin nskip = 1'b1; nload = 1'b1; nacc = CTRL_WORD; end
      OP_GET_VEC:  begin nskip = 1'b1; nload = 1'b1; nacc = VEC_WORD;  end
      OP_PUT_CHAR: nskip = 1'b1;
      OP_PUT_NOP:  nskip = 1'b1;
      default:     nskip = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_skip  <= 1'b0;
      resp_load  <= 1'b0;
      acc_out    <= '0;
      err_flag   <= 1'b0;
    end else begin
      resp_valid <= cmd_valid;
      resp_skip  <= cmd_valid && nskip;
      resp_load  <= cmd_valid && nload;
      if (cmd_valid) acc_out <= nacc;
      if (cmd_valid && op == OP_BAD) err_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/tty_pio_port_chk.sv
module tty_pio_port_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          resp_valid,
  input logic          resp_skip,
  input logic          resp_load,
  input logic          err_flag,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [CW-1:0] tx_data
);

  AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> resp_valid); // R1
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !resp_valid); // R1
  AST_LOAD_NEEDS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_load |-> (resp_skip && resp_valid)); // R4
  AST_RX_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7
  AST_TX_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_data[CW-1]); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R9

endmodule

bind tty_pio_port tty_pio_port_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .resp_valid (resp_valid),
  .resp_skip  (resp_skip),
  .resp_load  (resp_load),
  .err_flag   (err_flag),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data)
);

// File: tb/sim_tty_pio_port.sv
module sim_tty_pio_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_class = 2'd0;
  logic [5:0]  cmd_func = 6'd0;
  logic [15:0] acc_in = 16'd0;
  logic        resp_valid, resp_skip, resp_load, err_flag, rx_ready, tx_valid;
  logic [15:0] acc_out;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'd0;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;

  always #4 clk = ~clk;

  tty_pio_port u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
    .cmd_func(cmd_func), .acc_in(acc_in), .resp_valid(resp_valid),
    .resp_skip(resp_skip), .resp_load(resp_load), .acc_out(acc_out),
    .err_flag(err_flag), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready)
  );

  typedef struct {
    logic        skip;
    logic        load;
    logic [15:0] acc;
    string       tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] tx_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one command, expected response goes to the scoreboard
  task automatic issue(input logic [1:0] cls, input logic [5:0] fn, input logic [15:0] a,
                       input logic sk, input logic ld, input logic [15:0] ea,
                       input logic etake, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_class = cls; cmd_func = fn; acc_in = a;
    e.skip = sk; e.load = ld; e.acc = ea; e.tag = tag;
    sb_q.push_back(e);
    #1;
    check({tag, " rx_ready"}, {31'd0, rx_ready}, {31'd0, etake});
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor: compares responses and transmitted bytes
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb_q.size() == 0) check("R1 unexpected response", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " skip"}, {31'd0, resp_skip}, {31'd0, e.skip});
        check({e.tag, " load"}, {31'd0, resp_load}, {31'd0, e.load});
        check({e.tag, " acc"},  {16'd0, acc_out},   {16'd0, e.acc});
      end
    end
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_q.size() == 0) check("R6 unexpected tx byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
      else check("R6 tx byte", {24'd0, tx_data}, {24'd0, tx_q.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 resp_valid", {31'd0, resp_valid}, 32'd0);
    check("R10 err_flag",   {31'd0, err_flag},   32'd0);
    check("R10 tx_valid",   {31'd0, tx_valid},   32'd0);
    check("R10 rx_ready",   {31'd0, rx_ready},   32'd0);
    rst_n = 1'b1;

    // R2 skip-test on receive availability
    rx_valid = 1'b0;
    issue(2'd1, 6'o07, 16'h1234, 0, 0, 16'h1234, 0, "R2 empty");
    rx_valid = 1'b1; rx_data = 8'h41;
    issue(2'd1, 6'o07, 16'h1234, 1, 0, 16'h1234, 0, "R2 ready");

    // R3 character input, merging and clearing variants
    issue(2'd2, 6'o00, 16'h1200, 1, 1, 16'h12C1, 1, "R3 merge");
    rx_data = 8'h05;
    issue(2'd2, 6'o10, 16'hFFFF, 1, 1, 16'h0085, 1, "R3 clear");
    rx_data = 8'hC3;
    issue(2'd2, 6'o00, 16'h0000, 1, 1, 16'h00C3, 1, "R3 high bit");
    rx_valid = 1'b0;

    // R4 input with nothing received
    issue(2'd2, 6'o10, 16'hBEEF, 0, 0, 16'hBEEF, 0, "R4 clear empty");
    issue(2'd2, 6'o00, 16'h0102, 0, 0, 16'h0102, 0, "R4 merge empty");

    // R5 constants
    issue(2'd2, 6'o12, 16'h0005, 1, 1, 16'h0848, 0, "R5 ctrl word");
    issue(2'd2, 6'o17, 16'hFFFF, 1, 1, 16'h0000, 0, "R5 vector");

    // R6 character output
    tx_q.push_back(8'h41);
    issue(2'd3, 6'o00, 16'h7F41, 1, 0, 16'h7F41, 0, "R6 send");
    issue(2'd3, 6'o00, 16'h1200, 1, 0, 16'h1200, 0, "R6 zero char");
    tx_q.push_back(8'h42);
    issue(2'd3, 6'o00, 16'h00C2, 1, 0, 16'h00C2, 0, "R6 strip");
    tx_q.push_back(8'h00);
    issue(2'd3, 6'o00, 16'h0080, 1, 0, 16'h0080, 0, "R6 only top bit");
    repeat (3) @(negedge clk);
    check("R6 drained", tx_q.size(), 32'd0);

    // R7 back-pressure and discard on full holding register
    tx_ready = 1'b0;
    tx_q.push_back(8'h48);
    issue(2'd3, 6'o00, 16'h0048, 1, 0, 16'h0048, 0, "R7 first");
    issue(2'd3, 6'o00, 16'h0049, 1, 0, 16'h0049, 0, "R7 discarded");
    repeat (3) @(negedge clk);
    check("R7 held valid", {31'd0, tx_valid}, 32'd1);
    check("R7 held data",  {24'd0, tx_data},  32'h48);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 drained", {31'd0, tx_valid}, 32'd0);
    check("R7 queue",   tx_q.size(), 32'd0);

    // R8 accepted control writes with no side effect
    issue(2'd3, 6'o01, 16'h0041, 1, 0, 16'h0041, 0, "R8 ctl word");
    issue(2'd3, 6'o04, 16'h0042, 1, 0, 16'h0042, 0, "R8 reg lo");
    issue(2'd3, 6'o07, 16'h0055, 1, 0, 16'h0055, 0, "R8 reg hi");
    repeat (2) @(negedge clk);
    check("R8 no tx", {31'd0, tx_valid}, 32'd0);
    check("R8 no error", {31'd0, err_flag}, 32'd0);

    // R9 undefined codes
    rx_valid = 1'b1; rx_data = 8'h33;
    issue(2'd2, 6'o03, 16'h0011, 0, 0, 16'h0011, 0, "R9 input 3");
    check("R9 flag set", {31'd0, err_flag}, 32'd1);
    issue(2'd2, 6'o11, 16'h0022, 0, 0, 16'h0022, 0, "R9 input 11");
    issue(2'd0, 6'o15, 16'h0033, 0, 0, 16'h0033, 0, "R9 pulse");
    issue(2'd1, 6'o04, 16'h0044, 0, 0, 16'h0044, 0, "R9 test 4");
    issue(2'd3, 6'o02, 16'h0066, 0, 0, 16'h0066, 0, "R9 output 2");
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 flag sticky", {31'd0, err_flag}, 32'd1);
    check("R9 no tx", {31'd0, tx_valid}, 32'd0);

    // R10 reset clears the flag
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 flag cleared", {31'd0, err_flag}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 scoreboard empty", sb_q.size(), 32'd0);
    check("R6 tx queue empty",   tx_q.size(), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule